// File: doc/BRIEF.md
# ISA Memory Window 16-bit Decoder

This block watches the latched upper address lines of an ISA bus and compares them against two programmable memory windows, A and B. For each window it drives an active-low chip select. It also decides whether the addressed memory is 16 bits wide. That indication goes to an open-drain bus pin as a pad output-enable, and the pad's data value is held low. Only LA[23:17] take part in the decode. A 16-bit flag therefore covers every whole 128 KB block that a window touches.

The configuration is held in two logical-device register banks. A plain write port loads them, using a device number, an 8-bit register index, an 8-bit data value and a strobe. Window A always belongs to device 0, window 0. A two-bit submode chooses which bank owns window B. In submodes 0 and 1 it is device 0, window 1. In submodes 2 and 3 it is device 1, window 0.

When the mode input selects DMA operation, the shared pin becomes a transfer-ready output. It is driven only while the pin is configured as an output, and it stays tri-stated otherwise. In memory operation, an active-low refresh input blocks every memory chip-select output.

Top module: `memwin16_decoder`

## Requirements
- R1: After synchronous reset every configuration register is zero, so both chip selects are high, pad_oe is 0 and pad_do is 0.
- R2: A window hits when its activate bit is set and base[7:1] <= la <= limit[7:1], with both bounds inclusive. A hit drives that window's chip select low. la carries LA[23:17].
- R3: While a window's owning device has activate bit 0 (register 0x30, bit 0) clear, that window never hits.
- R4: In memory mode with refresh_n high, a window A hit sets pad_oe to 1 exactly when bit 1 of device 0 register 0x42 is set.
- R5: In submodes 0 and 1, window B uses device 0 registers 0x48 (base), 0x4B (limit) and 0x4A (bit 1 = 16-bit), together with the device 0 activate bit.
- R6: In submodes 2 and 3, window B uses device 1 registers 0x40 (base), 0x43 (limit) and 0x42 (bit 1 = 16-bit), together with the device 1 activate bit.
- R7: In memory mode with refresh_n low, both chip selects are high and pad_oe is 0, whatever the address.
- R8: In memory mode pad_do is always 0, so the pin is either driven low or released.
- R9: In DMA mode pad_oe equals dma_drv_en and pad_do equals dma_ready. Window 16-bit flags and refresh_n have no effect on the pin, and the chip selects are not gated by refresh_n.
- R10: A register write takes effect at the clock edge where cfg_wr is high. A write to an unmapped index, or any value presented while cfg_wr is low, changes nothing.
- R11: Only bits [7:1] of the base and limit bytes are compared. Bit 0 (A16) of those bytes has no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_dev | input | 1 | Target logical device |
| cfg_idx | input | 8 | Register index |
| cfg_data | input | 8 | Write data |
| submode | input | 2 | Window B ownership select |
| dma_mode | input | 1 | 1 = shared pin acts as DMA ready |
| dma_drv_en | input | 1 | Pin configured as output in DMA mode |
| dma_ready | input | 1 | Peripheral ready to transfer |
| refresh_n | input | 1 | Active-low refresh in progress |
| la | input | 7 | Latched address LA[23:17] |
| win_a_cs_n | output | 1 | Window A chip select, active low |
| win_b_cs_n | output | 1 | Window B chip select, active low |
| pad_oe | output | 1 | Shared pin output enable |
| pad_do | output | 1 | Shared pin data value |

## Verification
The address is stepped over the points one below, at and one above each bound, with the activate bits both clear and set. This separates an inclusive range compare from an exclusive one, and shows whether the activate bit gates the hit. Each of the four submode values is tried against windows programmed in both banks with different 16-bit bits, so that a swapped or wrongly decoded bank selection produces a wrong chip select or pad enable. Refresh and DMA patterns are applied while an address hits a 16-bit window, which shows whether the pin follows the memory decode or the DMA controls. Odd base and limit bytes, unmapped writes and writes with the strobe low check that A16 is ignored and that stray accesses leave the decode unchanged.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    parameter int LA_W     = 7;
    parameter int NUM_DEV  = 2;
    parameter int NUM_WIN  = 2;
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_WIN0    = 8'h40;
    localparam logic [7:0] WIN_STRIDE  = 8'h08;
    localparam logic [7:0] OFS_BASE    = 8'h00;
    localparam logic [7:0] OFS_CTRL    = 8'h02;
    localparam logic [7:0] OFS_LIMIT   = 8'h03;
    localparam int         CTRL_WIDE_B = 1;

    typedef struct packed {
        logic       act;
        logic [7:0] base;
        logic [7:0] limit;
        logic       wide;
    } win_cfg_t;

    function automatic logic [7:0] win_idx(input int w, input logic [7:0] ofs);
        return IDX_WIN0 + WIN_STRIDE * w[7:0] + ofs;
    endfunction

    function automatic logic in_block(input logic [LA_W-1:0] a,
                                      input logic [7:0] lo,
                                      input logic [7:0] hi);
        return (a >= lo[7:8-LA_W]) && (a <= hi[7:8-LA_W]);
    endfunction
endpackage

// File: rtl/memwin_regbank.sv
module memwin_regbank
    import memwin_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr,
    input  logic [DEV_W-1:0]                dev,
    input  logic [7:0]                      idx,
    input  logic [7:0]                      data,
    output win_cfg_t [NUM_DEV*NUM_WIN-1:0]  cfg_o
);
    logic [NUM_DEV-1:0] act_q;
    logic [7:0] base_q  [NUM_DEV][NUM_WIN];
    logic [7:0] limit_q [NUM_DEV][NUM_WIN];
    logic       wide_q  [NUM_DEV][NUM_WIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            for (int d = 0; d < NUM_DEV; d++) begin
                for (int w = 0; w < NUM_WIN; w++) begin
                    base_q[d][w]  <= '0;
                    limit_q[d][w] <= '0;
                    wide_q[d][w]  <= 1'b0;
                end
            end
        end else if (wr) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                if (dev == d[DEV_W-1:0]) begin
                    if (idx == IDX_ACT) act_q[d] <= data[0];
                    for (int w = 0; w < NUM_WIN; w++) begin
                        if (idx == win_idx(w, OFS_BASE))  base_q[d][w]  <= data;
                        if (idx == win_idx(w, OFS_LIMIT)) limit_q[d][w] <= data;
                        if (idx == win_idx(w, OFS_CTRL))  wide_q[d][w]  <= data[CTRL_WIDE_B];
                    end
                end
            end
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            assign cfg_o[d*NUM_WIN+w] = '{act:   act_q[d],
                                          base:  base_q[d][w],
                                          limit: limit_q[d][w],
                                          wide:  wide_q[d][w]};
        end
    end

    // R10
    wr_act_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && dev == '0 && idx == IDX_ACT) |=> (cfg_o[0].act == $past(data[0])));
    // R10
    wr_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && dev == '0 && idx == win_idx(0, OFS_CTRL)) |=> (cfg_o[0].wide == $past(data[CTRL_WIDE_B])));
endmodule

// File: rtl/memwin_cmp.sv
module memwin_cmp
    import memwin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [LA_W-1:0] la,
    input  win_cfg_t        cfg,
    output logic            hit,
    output logic            hit16
);
    always_comb begin
        hit   = cfg.act && in_block(la, cfg.base, cfg.limit);
        hit16 = hit && cfg.wide;
    end

    // R3
    hit_needs_act_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> cfg.act);
endmodule

// File: rtl/memwin16_decoder.sv
module memwin16_decoder
    import memwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [DEV_W-1:0] cfg_dev,
    input  logic [7:0]       cfg_idx,
    input  logic [7:0]       cfg_data,
    input  logic [1:0]       submode,
    input  logic             dma_mode,
    input  logic             dma_drv_en,
    input  logic             dma_ready,
    input  logic             refresh_n,
    input  logic [LA_W-1:0]  la,
    output logic             win_a_cs_n,
    output logic             win_b_cs_n,
    output logic             pad_oe,
    output logic             pad_do
);
    localparam int WA_SLOT  = 0;
    localparam int WB_LOCAL = 1;
    localparam int WB_ALT   = NUM_WIN;

    win_cfg_t [NUM_DEV*NUM_WIN-1:0] cfg_all;
    win_cfg_t [1:0]                 sel_cfg;
    logic     [1:0]                 hit, hit16;
    logic                           cs_gate, wide16;

    memwin_regbank u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .dev(cfg_dev),
        .idx(cfg_idx), .data(cfg_data), .cfg_o(cfg_all)
    );

    always_comb begin
        sel_cfg[0] = cfg_all[WA_SLOT];
        sel_cfg[1] = submode[1] ? cfg_all[WB_ALT] : cfg_all[WB_LOCAL];
    end

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        memwin_cmp u_cmp (
            .clk(clk), .rst(rst), .la(la), .cfg(sel_cfg[w]),
            .hit(hit[w]), .hit16(hit16[w])
        );
    end

    always_comb begin
        cs_gate    = dma_mode | refresh_n;
        win_a_cs_n = ~(hit[0] & cs_gate);
        win_b_cs_n = ~(hit[1] & cs_gate);
        wide16     = (|hit16) & refresh_n & ~dma_mode;
        pad_oe     = dma_mode ? dma_drv_en : wide16;
        pad_do     = dma_mode & dma_ready;
    end

    // R7
    refresh_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!dma_mode && !refresh_n) |-> (win_a_cs_n && win_b_cs_n && !pad_oe));
    // R8
    mem_pad_low_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |-> !pad_do);
    // R4
    wide_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!dma_mode && pad_oe) |-> (!win_a_cs_n || !win_b_cs_n));
    // R9
    dma_pin_chk: assert property (@(posedge clk) disable iff (rst)
        dma_mode |-> (pad_oe == dma_drv_en && pad_do == dma_ready));
endmodule

// File: tb/sim_memwin16_decoder.sv
module sim_memwin16_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [0:0] cfg_dev = '0;
    logic [7:0] cfg_idx = '0, cfg_data = '0;
    logic [1:0] submode = '0;
    logic       dma_mode = 1'b0, dma_drv_en = 1'b0, dma_ready = 1'b0, refresh_n = 1'b1;
    logic [6:0] la = '0;
    logic       win_a_cs_n, win_b_cs_n, pad_oe, pad_do;

    typedef struct {
        logic  a_n, b_n, oe, dout;
        string tag;
    } exp_t;
    exp_t q[$];
    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    memwin16_decoder u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dev(cfg_dev),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .submode(submode),
        .dma_mode(dma_mode), .dma_drv_en(dma_drv_en), .dma_ready(dma_ready),
        .refresh_n(refresh_n), .la(la), .win_a_cs_n(win_a_cs_n),
        .win_b_cs_n(win_b_cs_n), .pad_oe(pad_oe), .pad_do(pad_do)
    );

    task automatic wr(input logic d, input logic [7:0] i, input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dev = d; cfg_idx = i; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic chk(input logic [6:0] a, input logic [1:0] sm, input logic rn,
                       input logic dm, input logic den, input logic rdy,
                       input logic ea, input logic eb, input logic eoe,
                       input logic edo, input string tag);
        exp_t e;
        @(negedge clk);
        la = a; submode = sm; refresh_n = rn;
        dma_mode = dm; dma_drv_en = den; dma_ready = rdy;
        e.a_n = ea; e.b_n = eb; e.oe = eoe; e.dout = edo; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compared++;
                if ({win_a_cs_n, win_b_cs_n, pad_oe, pad_do} !== {e.a_n, e.b_n, e.oe, e.dout}) begin
                    mismatched++;
                    $display("FAIL %s: got a_n=%b b_n=%b oe=%b do=%b, expected a_n=%b b_n=%b oe=%b do=%b",
                             e.tag, win_a_cs_n, win_b_cs_n, pad_oe, pad_do,
                             e.a_n, e.b_n, e.oe, e.dout);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(7'h10, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R1 reset state");
        // window A: la 0x10..0x12, 16-bit, inactive
        wr(0, 8'h40, 8'h20); wr(0, 8'h43, 8'h25); wr(0, 8'h42, 8'h02);
        chk(7'h10, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R3 inactive no hit");
        wr(0, 8'h30, 8'h01);
        chk(7'h10, 2'd0, 1, 0, 0, 0, 0, 1, 1, 0, "R2 R4 lower bound hit wide");
        chk(7'h12, 2'd0, 1, 0, 0, 0, 0, 1, 1, 0, "R2 upper bound hit");
        chk(7'h13, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R2 above limit");
        chk(7'h0F, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R2 below base");
        wr(0, 8'h42, 8'hFD);
        chk(7'h11, 2'd0, 1, 0, 0, 0, 0, 1, 0, 0, "R4 wide bit clear");
        // R10 strobe low and unmapped index
        @(negedge clk); cfg_dev = 0; cfg_idx = 8'h30; cfg_data = 8'h00;
        chk(7'h11, 2'd0, 1, 0, 0, 0, 0, 1, 0, 0, "R10 strobe low ignored");
        wr(0, 8'h45, 8'hFF); wr(0, 8'h31, 8'h00);
        chk(7'h11, 2'd0, 1, 0, 0, 0, 0, 1, 0, 0, "R10 unmapped write ignored");
        chk(7'h13, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R10 range unchanged");
        // R11 odd base/limit bytes: only la 0x10
        wr(0, 8'h40, 8'h21); wr(0, 8'h43, 8'h21); wr(0, 8'h42, 8'h02);
        chk(7'h10, 2'd0, 1, 0, 0, 0, 0, 1, 1, 0, "R11 A16 bit ignored hit");
        chk(7'h11, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R11 block above miss");
        // window B local: la 0x20, 16-bit
        wr(0, 8'h48, 8'h40); wr(0, 8'h4B, 8'h41); wr(0, 8'h4A, 8'h02);
        chk(7'h20, 2'd0, 1, 0, 0, 0, 1, 0, 1, 0, "R5 submode0 local B");
        chk(7'h20, 2'd1, 1, 0, 0, 0, 1, 0, 1, 0, "R5 submode1 local B");
        chk(7'h20, 2'd2, 1, 0, 0, 0, 1, 1, 0, 0, "R6 submode2 dev1 empty");
        // device 1 window 0: la 0x30, 8-bit
        wr(1, 8'h40, 8'h60); wr(1, 8'h43, 8'h60); wr(1, 8'h42, 8'h00);
        chk(7'h30, 2'd3, 1, 0, 0, 0, 1, 1, 0, 0, "R6 R3 dev1 inactive");
        wr(1, 8'h30, 8'h01);
        chk(7'h30, 2'd3, 1, 0, 0, 0, 1, 0, 0, 0, "R6 submode3 dev1 8-bit");
        chk(7'h30, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R5 submode0 ignores dev1");
        wr(1, 8'h42, 8'h02);
        chk(7'h30, 2'd2, 1, 0, 0, 0, 1, 0, 1, 0, "R6 submode2 dev1 16-bit");
        chk(7'h20, 2'd3, 1, 0, 0, 0, 1, 1, 0, 0, "R6 local B unused");
        // refresh
        chk(7'h10, 2'd0, 0, 0, 0, 0, 1, 1, 0, 0, "R7 refresh blocks A");
        chk(7'h20, 2'd0, 0, 0, 0, 0, 1, 1, 0, 0, "R7 refresh blocks B");
        // DMA mode
        chk(7'h10, 2'd0, 1, 1, 0, 1, 0, 1, 0, 1, "R9 dma pin disabled");
        chk(7'h10, 2'd0, 0, 1, 1, 1, 0, 1, 1, 1, "R9 dma ready driven");
        chk(7'h10, 2'd0, 1, 1, 1, 0, 0, 1, 1, 0, "R9 dma not ready");
        chk(7'h50, 2'd0, 1, 0, 0, 0, 1, 1, 0, 0, "R8 memory pad low");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule